// File: doc/BRIEF.md
# Manchester Line Encoder with Sync Preamble

This block turns a serial NRZ bit stream into a Manchester line signal carried on two complementary outputs. When a start request arrives it first sends a fixed preamble. The preamble is eight Manchester zero cells followed by a deliberately invalid synchronization pulse that is three bit periods wide. A receiver uses the preamble to lock onto the bit timing and to find where the payload begins.

The block also produces the bit clock that pulls NRZ data out of an external serial controller. This clock stays low for most of the preamble. It starts toggling in the last sync cell, so the first payload bit is already fetched when the sync pulse ends. Data is captured on the falling edge of that clock and sent in the next cell.

The block runs from a single oversampling clock at 16 or 32 times the bit rate. The rate is chosen per frame by a mode input. Payload bits follow each other without gaps for as long as the start request stays high.

Top module: `manchester_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txPos`, `txNeg` and `encClk` are all low.
- R2: During a frame `txNeg` is always the inverse of `txPos`, and the two outputs are never high together.
- R3: A frame opens with eight zero cells; each cell is low for its first half and high for its second half.
- R4: The preamble is followed by a sync pulse: three half-bit periods low, then three half-bit periods high.
- R5: A payload bit of 1 is high in the first half of its cell and low in the second; a bit of 0 is low, then high.
- R6: `encClk` is low through the eight zero cells and the first two sync cells. From the third sync cell onward it is high in the first half of each cell and low in the second half.
- R7: `sendData` is captured at the clock edge where `encClk` falls, and that value is sent in the following cell.
- R8: At the end of the sync pulse, and at the end of every payload cell, the frame continues only if `startReq` is high; otherwise the outputs return to idle at that boundary. Dropping `startReq` inside the preamble does not shorten the preamble.
- R9: With `osMode` = 0 a bit cell lasts 16 clocks (half cell 8); with `osMode` = 1 it lasts 32 clocks (half cell 16). The mode is sampled when the frame starts, and later changes have no effect until the next frame.
- R10: The first preamble half-cell begins at the clock edge where `startReq` is first seen high while idle.
- R11: A synchronous reset asserted during a frame returns all outputs to idle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (16x or 32x bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Starts a frame when idle; holds the payload going while high |
| osMode | input | 1 | Oversampling select: 0 = 16x, 1 = 32x |
| sendData | input | 1 | NRZ payload bit, captured at the falling edge of `encClk` |
| txPos | output | 1 | Manchester line output, true polarity |
| txNeg | output | 1 | Manchester line output, inverted polarity |
| encClk | output | 1 | Bit clock that strobes NRZ data in from the controller |

## Verification
Frames are driven at both oversampling rates. Payloads are all-zero, all-one and random, with lengths of one to ten bits. The line level is checked at the start and the middle of every half-cell, which separates a wrong cell length from a wrong polarity or a misplaced sync pulse. After each capture edge the bench drives `sendData` to the inverse value. A sampling point that is off by one half-cell then shows up as a wrong payload bit. Further directed cases cover the frame start, dropping the request inside the preamble, changing the mode mid-frame, and reset during a frame.

// File: rtl/manchester_tx_pkg.sv
package manchester_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_DATA
  } encState_t;

  // Strobes issued by the sequencer for the next half-cell
  typedef struct packed {
    logic load;      // a new half-cell starts at this edge
    logic active;    // frame in progress during the next half-cell
    logic useData;   // level comes from the captured payload bit
    logic invert;    // second half of a payload cell
    logic fixLevel;  // fixed level for preamble/sync halves
    logic clkLevel;  // encClk level for the next half-cell
    logic sample;    // capture sendData at this edge
  } encStrobe_t;

endpackage

// File: rtl/manchester_tx_ctl.sv
module manchester_tx_ctl
  import manchester_tx_pkg::*;
#(
  parameter int OVS_FAST = 16,
  parameter int OVS_SLOW = 32,
  parameter int PRE_BITS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       osMode,
  output encStrobe_t strobe,
  output encState_t  stateOut,
  output logic [$clog2(OVS_SLOW/2):0] tickOut
);

  localparam int HALF_FAST  = OVS_FAST / 2;
  localparam int HALF_SLOW  = OVS_SLOW / 2;
  localparam int TICK_W     = $clog2(HALF_SLOW) + 1;
  localparam int SYNC_SIDE  = 3;
  localparam int PRE_HALVES = 2 * PRE_BITS;
  localparam int MAX_HALVES = (PRE_HALVES > 2 * SYNC_SIDE) ? PRE_HALVES : 2 * SYNC_SIDE;
  localparam int HALF_W     = $clog2(MAX_HALVES);

  localparam logic [HALF_W-1:0] PRE_LAST  = HALF_W'(PRE_HALVES - 1);
  localparam logic [HALF_W-1:0] SYNC_LAST = HALF_W'(2 * SYNC_SIDE - 1);
  localparam logic [HALF_W-1:0] SYNC_CLK  = HALF_W'(2 * SYNC_SIDE - 2);
  localparam logic [HALF_W-1:0] SYNC_HIGH = HALF_W'(SYNC_SIDE);

  encState_t         state, nState;
  logic [TICK_W-1:0] tick, nTick;
  logic [TICK_W-1:0] halfLen;
  logic [HALF_W-1:0] halfNo, nHalf, halfInc;
  logic              halfEnd;

  assign halfEnd  = (state != ST_IDLE) && (tick == halfLen - 1'b1);
  assign halfInc  = halfNo + 1'b1;
  assign stateOut = state;
  assign tickOut  = tick;

  always_comb begin
    strobe = '0;
    nState = state;
    nHalf  = halfNo;
    nTick  = (state == ST_IDLE || halfEnd) ? '0 : tick + 1'b1;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          strobe.load   = 1'b1;
          strobe.active = 1'b1;
          nState        = ST_PRE;
          nHalf         = '0;
        end
      end
      ST_PRE: begin
        if (halfEnd) begin
          strobe.load   = 1'b1;
          strobe.active = 1'b1;
          if (halfNo == PRE_LAST) begin
            nState = ST_SYNC;
            nHalf  = '0;
          end else begin
            nHalf           = halfInc;
            strobe.fixLevel = ~halfNo[0];
          end
        end
      end
      ST_SYNC: begin
        if (halfEnd) begin
          strobe.load   = 1'b1;
          strobe.active = 1'b1;
          if (halfNo == SYNC_LAST) begin
            if (startReq) begin
              nState          = ST_DATA;
              nHalf           = '0;
              strobe.useData  = 1'b1;
              strobe.clkLevel = 1'b1;
            end else begin
              nState        = ST_IDLE;
              strobe.active = 1'b0;
            end
          end else begin
            nHalf           = halfInc;
            strobe.fixLevel = (halfInc >= SYNC_HIGH);
            strobe.clkLevel = (halfInc == SYNC_CLK);
            strobe.sample   = (halfInc == SYNC_LAST);
          end
        end
      end
      ST_DATA: begin
        if (halfEnd) begin
          strobe.load   = 1'b1;
          strobe.active = 1'b1;
          if (halfNo == '0) begin
            nHalf          = HALF_W'(1);
            strobe.useData = 1'b1;
            strobe.invert  = 1'b1;
            strobe.sample  = 1'b1;
          end else if (startReq) begin
            nHalf           = '0;
            strobe.useData  = 1'b1;
            strobe.clkLevel = 1'b1;
          end else begin
            nState        = ST_IDLE;
            strobe.active = 1'b0;
          end
        end
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      tick    <= '0;
      halfNo  <= '0;
      halfLen <= TICK_W'(HALF_FAST);
    end else begin
      state  <= nState;
      tick   <= nTick;
      halfNo <= nHalf;
      if (state == ST_IDLE && startReq)
        halfLen <= osMode ? TICK_W'(HALF_SLOW) : TICK_W'(HALF_FAST);
    end
  end

  // R9: tick never leaves the half-cell window chosen at frame start
  a_r9_tick_range: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (tick < halfLen));

  // R9: the latched half-cell length is constant while a frame runs
  a_r9_len_held: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(halfLen));

endmodule

// File: rtl/manchester_tx_dp.sv
module manchester_tx_dp
  import manchester_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  encStrobe_t strobe,
  input  logic       sendData,
  output logic       txPos,
  output logic       txNeg,
  output logic       encClk
);

  logic dataReg;
  logic level;

  assign level = strobe.useData ? (dataReg ^ strobe.invert) : strobe.fixLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= 1'b0;
      txPos   <= 1'b0;
      txNeg   <= 1'b0;
      encClk  <= 1'b0;
    end else begin
      if (strobe.sample)
        dataReg <= sendData;
      if (strobe.load) begin
        txPos  <= strobe.active & level;
        txNeg  <= strobe.active & ~level;
        encClk <= strobe.active & strobe.clkLevel;
      end
    end
  end

  // R2: the two line outputs are never driven high together
  a_r2_not_both: assert property (@(posedge clk) disable iff (rst)
    !(txPos && txNeg));

  // R7: a capture edge is always a falling edge of encClk
  a_r7_sample_on_fall: assert property (@(posedge clk) disable iff (rst)
    strobe.sample |-> encClk);

endmodule

// File: rtl/manchester_tx.sv
module manchester_tx
  import manchester_tx_pkg::*;
#(
  parameter int OVS_FAST = 16,
  parameter int OVS_SLOW = 32,
  parameter int PRE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic startReq,
  input  logic osMode,
  input  logic sendData,
  output logic txPos,
  output logic txNeg,
  output logic encClk
);

  localparam int TICK_W = $clog2(OVS_SLOW / 2) + 1;

  encStrobe_t        strobe;
  encState_t         state;
  logic [TICK_W-1:0] tick;

  manchester_tx_ctl #(
    .OVS_FAST(OVS_FAST),
    .OVS_SLOW(OVS_SLOW),
    .PRE_BITS(PRE_BITS)
  ) u_ctl (
    .clk     (clk),
    .rst     (rst),
    .startReq(startReq),
    .osMode  (osMode),
    .strobe  (strobe),
    .stateOut(state),
    .tickOut (tick)
  );

  manchester_tx_dp u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .sendData(sendData),
    .txPos   (txPos),
    .txNeg   (txNeg),
    .encClk  (encClk)
  );

  // R1: idle sequencer implies a quiet line and a parked bit clock
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (!txPos && !txNeg && !encClk));

  // R2: inside a frame the outputs are complementary
  a_r2_complement: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (txNeg == !txPos));

  // R6: no data strobe while the zero cells are on the line
  a_r6_pre_no_clock: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE) |-> !encClk);

  // R5: every payload cell flips the line at mid-cell
  a_r5_mid_transition: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DATA && strobe.load && strobe.invert) |=> (txPos != $past(txPos)));

  // R3: the line level only moves at half-cell boundaries
  a_r3_half_stable: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && tick != '0) |-> ($stable(txPos) && $stable(encClk)));

endmodule

// File: tb/tb_manchester_tx.sv
`timescale 1ns/1ps
module tb_manchester_tx;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic osMode = 1'b0;
  logic sendData = 1'b0;
  logic txPos, txNeg, encClk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  manchester_tx dut (
    .clk(clk), .rst(rst), .startReq(startReq), .osMode(osMode),
    .sendData(sendData), .txPos(txPos), .txNeg(txNeg), .encClk(encClk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  function automatic logic expLevel(input int g, input logic [31:0] b);
    int k;
    if (g < 16) return logic'(g % 2);
    if (g < 19) return 1'b0;
    if (g < 22) return 1'b1;
    k = (g - 22) / 2;
    return (g % 2 == 0) ? b[k] : !b[k];
  endfunction

  function automatic logic expClk(input int g, input int nSent);
    return (g >= 20) && (g % 2 == 0) && (g < 22 + 2 * nSent);
  endfunction

  function automatic string reqOf(input int g);
    if (g < 16) return "R3";
    if (g < 22) return "R4";
    return "R5";
  endfunction

  task automatic runFrame(input bit modeSel, input int nBits, input int dropHalf,
                          input logic [31:0] bits, input bit flipMode);
    int h, nSent, endHalf, g, p;
    h = modeSel ? 16 : 8;
    nSent = (dropHalf <= 21) ? 0 : (dropHalf - 20) / 2;
    if (nSent > nBits) nSent = nBits;
    endHalf = 22 + 2 * nSent;
    @(negedge clk);
    osMode = modeSel;
    startReq = 1'b1;
    sendData = 1'b0;
    for (int c = 0; c < endHalf * h + 3; c++) begin
      @(negedge clk);
      g = c / h;
      p = c % h;
      if (c == 0)
        check(txNeg == 1'b1 && txPos == 1'b0, "R10", {txPos, txNeg}, 1);
      if (g < endHalf && (p == 0 || p == h / 2)) begin
        check(txPos == expLevel(g, bits), (p == 0) ? "R9" : reqOf(g), txPos, expLevel(g, bits));
        check(txNeg == !txPos, "R2", txNeg, !txPos);
        check(encClk == expClk(g, nSent), (g >= 22) ? "R7" : "R6", encClk, expClk(g, nSent));
      end
      if (g < endHalf && p == h / 2) begin
        if (g >= 20 && g % 2 == 0 && (g - 20) / 2 < nBits)
          sendData = bits[(g - 20) / 2];
        if (g == dropHalf) startReq = 1'b0;
        if (flipMode && g == 3) osMode = !modeSel;
      end
      if (g >= 21 && g < endHalf && g % 2 == 1 && p == 1)
        sendData = !bits[(g - 21) / 2];
      if (c == endHalf * h + 1)
        check(!txPos && !txNeg && !encClk, "R8", {txPos, txNeg, encClk}, 0);
    end
    osMode = modeSel;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!txPos && !txNeg && !encClk, "R1", {txPos, txNeg, encClk}, 0);

    // R1: startReq low, data toggling, line stays quiet
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      sendData = !sendData;
    end
    check(!txPos && !txNeg && !encClk, "R1", {txPos, txNeg, encClk}, 0);

    // Directed: all zeros / all ones at each rate
    runFrame(1'b0, 4, 21 + 8, 32'h0, 1'b0);
    runFrame(1'b1, 4, 21 + 8, 32'hFFFF_FFFF, 1'b0);
    runFrame(1'b0, 6, 21 + 12, 32'h2D, 1'b0);
    // R8: request dropped inside the preamble, full preamble then idle
    runFrame(1'b0, 3, 5, 32'h7, 1'b0);
    // R8: request dropped during the sync pulse, no payload
    runFrame(1'b1, 2, 18, 32'h3, 1'b0);
    // R8: request dropped in first half of last payload cell
    runFrame(1'b1, 3, 20 + 6, 32'h5, 1'b0);
    // R9: mode flipped mid-frame has no effect
    runFrame(1'b0, 5, 21 + 10, 32'h19, 1'b1);
    runFrame(1'b1, 5, 21 + 10, 32'h0A, 1'b1);

    // Random frames
    for (int f = 0; f < 12; f++) begin
      int n;
      bit m;
      logic [31:0] b;
      m = 1'($urandom % 2);
      n = 1 + int'($urandom % 10);
      b = $urandom;
      runFrame(m, n, ($urandom % 2 == 0) ? 21 + 2 * n : 20 + 2 * n, b, 1'b0);
      repeat (int'($urandom % 5)) @(negedge clk);
    end

    // R11: reset in the middle of a frame
    @(negedge clk);
    osMode = 1'b0;
    startReq = 1'b1;
    repeat (100) @(negedge clk);
    check(txNeg == !txPos && (txPos || txNeg), "R11", {txPos, txNeg}, 1);
    rst = 1'b1;
    startReq = 1'b0;
    @(negedge clk);
    check(!txPos && !txNeg && !encClk, "R11", {txPos, txNeg, encClk}, 0);
    rst = 1'b0;
    repeat (30) @(negedge clk);
    check(!txPos && !txNeg && !encClk, "R1", {txPos, txNeg, encClk}, 0);

    // After reset a new frame still starts cleanly
    runFrame(1'b1, 2, 21 + 4, 32'h1, 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule